// File: doc/BRIEF.md
# Host Transfer Address Sequencer

This block produces the buffer RAM address for each word moved between a local buffer and a host port, and it counts the words still to go. A microcontroller sets up a transfer through a small byte-wide register port. It writes a 12-bit word count, a mode bit and a direction bit, and then the start position. The start position is either one linear address, or a block number together with an offset inside that block. Writing to the trigger register starts the transfer. After that, every host word strobe moves the address on by one and takes one off the count.

In block mode the address is the block number times a block size (an input, in words) plus the offset. The offset wraps back to zero at the end of the block, so a transfer never leaves its block. In linear mode the address simply counts up. While linear mode is selected, a busy output tells the microcontroller to keep away from the buffer RAM. After the final word, an end-of-transfer flag rises and stays up until software clears it. For buffer-to-host transfers a prefill request and an active-low FIFO-ready flag are produced for the external FIFO.

Top module: `host_xfer_seq`

## Requirements
- R1: After reset, `xfer_active`, `end_irq`, `ram_busy`, `xfer_dir` and `prefill_req` are 0, `fifo_rdy_n` is 1, and `word_cnt` and `ram_addr` are 0.
- R2: A write to register 0 loads count bits [7:0]. A write to register 1 loads count bits [11:8] from data bits [3:0], the mode from bit 7 (1 = linear) and the direction from bit 6 (1 = host to buffer, seen on `xfer_dir`).
- R3: Any write to register 7 while idle sets `xfer_active` one cycle later, whatever data is written.
- R4: Each `word_ack` while active with a nonzero count lowers `word_cnt` by one, so a loaded value of N-1 moves exactly N words.
- R5: On the `word_ack` that finds `word_cnt` at 0, `xfer_active` clears, `end_irq` sets, and `word_cnt` stays at 0 with no underflow.
- R6: `end_irq` stays set until a write to register 8 with data bit 0 high. If a word end and such a clear fall in the same cycle, the flag ends up set.
- R7: In linear mode `ram_addr` equals a pointer loaded through register 2 (low byte) and register 3 (high byte). The pointer rises by one per word and wraps modulo 2^16.
- R8: In block mode `ram_addr` = block number (register 4) × `blk_size` + offset (register 5 low, register 6 high), truncated to 16 bits. The offset rises by one per word and returns to 0 after reaching `blk_size`-1.
- R9: `ram_busy` equals the programmed mode bit, high in linear mode.
- R10: With direction 0 and a transfer active, `prefill_req` is high while `fifo_ready` is low and `fifo_rdy_n` is low while `fifo_ready` is high. Otherwise `prefill_req` is 0 and `fifo_rdy_n` is 1.
- R11: While active, writes to registers 0–7 (including the trigger) have no effect. While idle, `word_ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| blk_size | input | 16 | Block size in words (held during a transfer) |
| word_ack | input | 1 | One host word moved this cycle |
| fifo_ready | input | 1 | External FIFO holds data |
| ram_addr | output | 16 | Buffer RAM address of the current word |
| word_cnt | output | 12 | Remaining word count (minus one) |
| xfer_active | output | 1 | Transfer in progress |
| xfer_dir | output | 1 | Programmed direction, 1 = host to buffer |
| end_irq | output | 1 | End-of-transfer flag |
| ram_busy | output | 1 | Microcontroller RAM access blocked (linear mode) |
| fifo_rdy_n | output | 1 | Active-low FIFO-ready flag |
| prefill_req | output | 1 | Request to prefill the FIFO |

## Verification
The assertions check a set of rules on every cycle: the single-step countdown, the final-word hand-off to the flag with no underflow, the flag staying set until cleared, the linear increment, the block-offset wrap, that register writes during a transfer and idle strobes are ignored, and that the FIFO flag appears only for an active buffer-to-host transfer. Some behaviour can only be shown by the bench's scenarios. These are: the exact addresses produced for a given block number, size and offset, the wrap of the linear pointer at the top of the address space, and the set-over-clear ordering of the flag. The same holds for the full word totals across randomly programmed transfers, which are compared against a bench model.

// File: rtl/hxs_pkg.sv
// Shared register selects and bit positions for the host transfer sequencer.
// Assumes an 8-bit microcontroller write port with a 4-bit register select.
package hxs_pkg;
    typedef enum logic [3:0] {
        SEL_CNT_LO  = 4'd0,
        SEL_CNT_HI  = 4'd1,
        SEL_LIN_LO  = 4'd2,
        SEL_LIN_HI  = 4'd3,
        SEL_BLK     = 4'd4,
        SEL_OFF_LO  = 4'd5,
        SEL_OFF_HI  = 4'd6,
        SEL_TRIG    = 4'd7,
        SEL_IRQ_CLR = 4'd8
    } reg_sel_e;

    localparam int MODE_BIT = 7;
    localparam int DIR_BIT  = 6;
endpackage

// File: rtl/hxs_ctrl.sv
// Word counter, transfer-active state and end-of-transfer flag.
// Assumes CNT_W is between 9 and 16; load strobes are already gated off
// during a transfer by the parent.
module hxs_ctrl #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       wdata,
    input  logic             trig,
    input  logic             step,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             irq
);
    localparam int HI_W = CNT_W - 8;

    logic last_word;
    assign last_word = step && (cnt == '0);

    // Count register: byte loads from software, countdown per word, floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            if (ld_lo) cnt[7:0] <= wdata;
            if (ld_hi) cnt[CNT_W-1:8] <= wdata[HI_W-1:0];
            if (step && cnt != '0) cnt <= cnt - CNT_W'(1);
        end
    end

    // Active state: start on trigger, stop after the word that finds zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         active <= 1'b0;
        else if (trig)      active <= 1'b1;
        else if (last_word) active <= 1'b0;
    end

    // End flag: set by the final word (set wins), cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (last_word) irq <= 1'b1;
        else if (irq_clr)   irq <= 1'b0;
    end
endmodule

// File: rtl/hxs_addr.sv
// Address pointers and RAM address formation for both modes.
// Assumes ADDR_W is between 9 and 16 and that blk_size is held steady while
// a block-mode transfer runs.
module hxs_addr #(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lin_mode,
    input  logic              ld_lin_lo,
    input  logic              ld_lin_hi,
    input  logic              ld_blk,
    input  logic              ld_off_lo,
    input  logic              ld_off_hi,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] blk_size,
    input  logic              step,
    output logic [ADDR_W-1:0] off_ptr,
    output logic [ADDR_W-1:0] ram_addr
);
    localparam int HI_W = ADDR_W - 8;
    localparam int PW   = ADDR_W + BLK_W;

    logic [ADDR_W-1:0] lin_ptr;
    logic [BLK_W-1:0]  blk_num;
    logic [PW-1:0]     blk_base;
    logic [ADDR_W-1:0] wrap_pt;

    assign wrap_pt = blk_size - ADDR_W'(1);

    // Linear pointer: byte loads, one step per word in linear mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_ptr <= '0;
        end else begin
            if (ld_lin_lo) lin_ptr[7:0] <= wdata;
            if (ld_lin_hi) lin_ptr[ADDR_W-1:8] <= wdata[HI_W-1:0];
            if (step && lin_mode) lin_ptr <= lin_ptr + ADDR_W'(1);
        end
    end

    // Block number register.
    always_ff @(posedge clk) begin
        if (!rst_n)      blk_num <= '0;
        else if (ld_blk) blk_num <= wdata[BLK_W-1:0];
    end

    // In-block offset: byte loads, step per word in block mode, wrap at block end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_ptr <= '0;
        end else begin
            if (ld_off_lo) off_ptr[7:0] <= wdata;
            if (ld_off_hi) off_ptr[ADDR_W-1:8] <= wdata[HI_W-1:0];
            if (step && !lin_mode)
                off_ptr <= (off_ptr >= wrap_pt) ? '0 : off_ptr + ADDR_W'(1);
        end
    end

    // Address select: linear pointer, or block base plus offset.
    always_comb begin
        blk_base = PW'(blk_num) * PW'(blk_size);
        ram_addr = lin_mode ? lin_ptr : blk_base[ADDR_W-1:0] + off_ptr;
    end
endmodule

// File: rtl/host_xfer_seq.sv
// Top of the host transfer sequencer: decodes microcontroller register
// writes, holds mode and direction, and drives the FIFO handshake flags.
// Assumes writes other than the flag clear are meant only for idle periods.
module host_xfer_seq #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [ADDR_W-1:0] blk_size,
    input  logic              word_ack,
    input  logic              fifo_ready,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [CNT_W-1:0]  word_cnt,
    output logic              xfer_active,
    output logic              xfer_dir,
    output logic              end_irq,
    output logic              ram_busy,
    output logic              fifo_rdy_n,
    output logic              prefill_req
);
    import hxs_pkg::*;

    logic              cfg_wr;
    logic              step;
    logic              irq_clr;
    logic              lin_mode;
    logic [ADDR_W-1:0] off_ptr;

    assign cfg_wr  = reg_wr_en && !xfer_active;
    assign step    = word_ack && xfer_active;
    assign irq_clr = reg_wr_en && (reg_addr == SEL_IRQ_CLR) && reg_wdata[0];

    // Mode and direction bits live beside the high count bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_mode <= 1'b0;
            xfer_dir <= 1'b0;
        end else if (cfg_wr && reg_addr == SEL_CNT_HI) begin
            lin_mode <= reg_wdata[MODE_BIT];
            xfer_dir <= reg_wdata[DIR_BIT];
        end
    end

    hxs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (cfg_wr && reg_addr == SEL_CNT_LO),
        .ld_hi   (cfg_wr && reg_addr == SEL_CNT_HI),
        .wdata   (reg_wdata),
        .trig    (cfg_wr && reg_addr == SEL_TRIG),
        .step    (step),
        .irq_clr (irq_clr),
        .cnt     (word_cnt),
        .active  (xfer_active),
        .irq     (end_irq)
    );

    hxs_addr #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .lin_mode  (lin_mode),
        .ld_lin_lo (cfg_wr && reg_addr == SEL_LIN_LO),
        .ld_lin_hi (cfg_wr && reg_addr == SEL_LIN_HI),
        .ld_blk    (cfg_wr && reg_addr == SEL_BLK),
        .ld_off_lo (cfg_wr && reg_addr == SEL_OFF_LO),
        .ld_off_hi (cfg_wr && reg_addr == SEL_OFF_HI),
        .wdata     (reg_wdata),
        .blk_size  (blk_size),
        .step      (step),
        .off_ptr   (off_ptr),
        .ram_addr  (ram_addr)
    );

    // RAM lockout follows the mode; FIFO flags only for buffer-to-host transfers.
    always_comb begin
        ram_busy    = lin_mode;
        fifo_rdy_n  = !(xfer_active && !xfer_dir && fifo_ready);
        prefill_req = xfer_active && !xfer_dir && !fifo_ready;
    end
endmodule

// File: rtl/hxs_checker.sv
// Cycle-level rules for the host transfer sequencer, bound into the top.
module hxs_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [3:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [ADDR_W-1:0] blk_size,
    input logic              word_ack,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [CNT_W-1:0]  word_cnt,
    input logic              xfer_active,
    input logic              xfer_dir,
    input logic              end_irq,
    input logic              fifo_rdy_n,
    input logic              lin_mode,
    input logic [ADDR_W-1:0] off_ptr
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && word_ack && word_cnt != '0) |=> (word_cnt + CNT_W'(1)) == $past(word_cnt)); // R4
    AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && word_ack && word_cnt == '0) |=> (end_irq && !xfer_active && word_cnt == '0)); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (end_irq && !(reg_wr_en && reg_addr == 4'd8 && reg_wdata[0])) |=> end_irq); // R6
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && word_ack && lin_mode) |=> ram_addr == $past(ram_addr) + ADDR_W'(1)); // R7
    AST_BLK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && word_ack && !lin_mode && off_ptr == blk_size - ADDR_W'(1)) |=> off_ptr == '0); // R8
    AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && reg_wr_en && reg_addr != 4'd8 && !word_ack) |=> ($stable(word_cnt) && xfer_active)); // R11
    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && word_ack && !reg_wr_en) |=> ($stable(word_cnt) && !xfer_active)); // R11
    AST_FIFO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rdy_n |-> (xfer_active && !xfer_dir)); // R10
endmodule

bind host_xfer_seq hxs_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .blk_size    (blk_size),
    .word_ack    (word_ack),
    .ram_addr    (ram_addr),
    .word_cnt    (word_cnt),
    .xfer_active (xfer_active),
    .xfer_dir    (xfer_dir),
    .end_irq     (end_irq),
    .fifo_rdy_n  (fifo_rdy_n),
    .lin_mode    (lin_mode),
    .off_ptr     (off_ptr)
);

// File: tb/tb_host_xfer_seq.sv
`timescale 1ns/1ps
module tb_host_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] blk_size = 16'd4;
    logic        word_ack = 1'b0;
    logic        fifo_ready = 1'b0;
    logic [15:0] ram_addr;
    logic [11:0] word_cnt;
    logic        xfer_active, xfer_dir, end_irq, ram_busy, fifo_rdy_n, prefill_req;

    int n_chk = 0;
    int n_bad = 0;

    int m_cnt, m_lin, m_blk, m_off, m_size;
    bit m_mode, m_dir;

    always #2.5 clk = ~clk;

    host_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .blk_size(blk_size), .word_ack(word_ack),
        .fifo_ready(fifo_ready), .ram_addr(ram_addr), .word_cnt(word_cnt),
        .xfer_active(xfer_active), .xfer_dir(xfer_dir), .end_irq(end_irq),
        .ram_busy(ram_busy), .fifo_rdy_n(fifo_rdy_n), .prefill_req(prefill_req)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr();
        if (m_mode) return m_lin & 16'hFFFF;
        return (m_blk * m_size + m_off) & 16'hFFFF;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic setup(bit mode, bit dir, int cnt, int lin, int blk, int off, int size);
        blk_size = 16'(size);
        wr(4'd0, 8'(cnt));
        wr(4'd1, {mode, dir, 2'b00, 4'(cnt >> 8)});
        wr(4'd2, 8'(lin)); wr(4'd3, 8'(lin >> 8));
        wr(4'd4, 8'(blk));
        wr(4'd5, 8'(off)); wr(4'd6, 8'(off >> 8));
        m_mode = mode; m_dir = dir; m_cnt = cnt; m_lin = lin;
        m_blk = blk; m_off = off; m_size = size;
    endtask

    // One host word: check address and count, strobe, update the model.
    task automatic word(string req);
        chk(req, int'(ram_addr), exp_addr());
        chk("R4", int'(word_cnt), m_cnt);
        word_ack = 1'b1;
        @(negedge clk);
        word_ack = 1'b0;
        if (m_mode) m_lin = (m_lin + 1) & 16'hFFFF;
        else m_off = (m_off >= m_size - 1) ? 0 : m_off + 1;
        if (m_cnt != 0) m_cnt--;
    endtask

    task automatic run_all(string req);
        int n = m_cnt + 1;
        for (int i = 0; i < n; i++) begin
            chk("R4", int'(xfer_active), 1);
            word(req);
        end
        chk("R5", int'(xfer_active), 0);
        chk("R5", int'(end_irq), 1);
        chk("R5", int'(word_cnt), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(xfer_active), 0); chk("R1", int'(end_irq), 0);
        chk("R1", int'(ram_busy), 0);    chk("R1", int'(xfer_dir), 0);
        chk("R1", int'(fifo_rdy_n), 1);  chk("R1", int'(prefill_req), 0);
        chk("R1", int'(word_cnt), 0);    chk("R1", int'(ram_addr), 0);

        // R2 split count load, mode and direction bits
        wr(4'd0, 8'h34); wr(4'd1, 8'hCA);
        chk("R2", int'(word_cnt), 12'hA34);
        chk("R2", int'(xfer_dir), 1);
        chk("R9", int'(ram_busy), 1);

        // R8 block mode with wrap: block 3, size 4, offset 2, six words
        setup(0, 0, 5, 0, 3, 2, 4);
        chk("R9", int'(ram_busy), 0);
        wr(4'd7, 8'h5A);
        chk("R3", int'(xfer_active), 1);
        run_all("R8");

        // R11 idle strobe ignored
        word_ack = 1'b1; @(negedge clk); word_ack = 1'b0;
        chk("R11", int'(word_cnt), 0); chk("R11", int'(xfer_active), 0);
        chk("R11", int'(ram_addr), exp_addr());

        // R6 flag holds, a clear with bit 0 low is no clear, bit 0 high clears
        repeat (3) @(negedge clk);
        chk("R6", int'(end_irq), 1);
        wr(4'd8, 8'hFE); chk("R6", int'(end_irq), 1);
        wr(4'd8, 8'h01); chk("R6", int'(end_irq), 0);

        // R7 linear wrap at top of address space
        setup(1, 0, 2, 16'hFFFE, 0, 0, 4);
        chk("R9", int'(ram_busy), 1);
        wr(4'd7, 8'h00);
        run_all("R7");
        wr(4'd8, 8'h01);

        // R11 writes during a transfer ignored, R10 FIFO flags
        setup(0, 0, 3, 0, 1, 0, 8);
        fifo_ready = 1'b0;
        wr(4'd7, 8'hFF);
        chk("R10", int'(prefill_req), 1); chk("R10", int'(fifo_rdy_n), 1);
        fifo_ready = 1'b1; #1;
        chk("R10", int'(prefill_req), 0); chk("R10", int'(fifo_rdy_n), 0);
        wr(4'd0, 8'h77); wr(4'd5, 8'h05); wr(4'd7, 8'h00);
        chk("R11", int'(word_cnt), 3); chk("R11", int'(ram_addr), exp_addr());
        chk("R11", int'(xfer_active), 1);
        run_all("R8");
        chk("R10", int'(fifo_rdy_n), 1);
        fifo_ready = 1'b0;
        wr(4'd8, 8'h01);

        // R10 host-to-buffer direction gives no FIFO flags
        setup(0, 1, 1, 0, 0, 0, 4);
        fifo_ready = 1'b1;
        wr(4'd7, 8'h00);
        chk("R10", int'(fifo_rdy_n), 1); chk("R10", int'(prefill_req), 0);
        run_all("R8");
        fifo_ready = 1'b0;

        // R6 final word and clear in the same cycle: set wins
        wr(4'd8, 8'h01);
        setup(0, 0, 0, 0, 0, 0, 4);
        wr(4'd7, 8'h00);
        @(negedge clk);
        word_ack = 1'b1; reg_wr_en = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h01;
        @(negedge clk);
        word_ack = 1'b0; reg_wr_en = 1'b0;
        chk("R6", int'(end_irq), 1);
        wr(4'd8, 8'h01);

        // Random transfers against the bench model
        void'($urandom(32'd1234));
        for (int t = 0; t < 40; t++) begin
            int sz = 1 + int'($urandom % 8);
            bit md = 1'($urandom);
            setup(md, 1'($urandom), int'($urandom % 16), int'($urandom % 65536),
                  int'($urandom % 256), int'($urandom % sz), sz);
            chk("R9", int'(ram_busy), int'(md));
            wr(4'd7, 8'($urandom));
            chk("R3", int'(xfer_active), 1);
            run_all(md ? "R7" : "R8");
            wr(4'd8, 8'h01);
            chk("R6", int'(end_irq), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule